// File: doc/BRIEF.md
# ISA Logical Device Decoder and IRQ Router

This block sits between an ISA-style I/O bus and one serial-port logical device. It watches a 12-bit I/O address with the AEN qualifier and the active-low read and write strobes, compares address bits 9:3 against the device's base address and, on a match, raises a device select. Along with the select it passes on a 3-bit register index from address bits 2:0 and gated read and write enables. Address bits 11:10 take no part in the compare.

The same block routes the device's interrupt to exactly one of ten ISA IRQ lines. Each line has a value output and an output enable, so the pad drives it high or low when it is the chosen line and leaves it floating otherwise. The routed request is the OR of the device's four interrupt sources. In UART-bypass mode an external interrupt input is routed in its place.

The base address, IRQ level and an activate bit are captured from configuration inputs into registers that reset to power-up values. When the strap-driven bypass mode is on, two address-configure pins and four IRQ-configure pins are used instead of those registers. All outputs are registered.

Top module: `isa_ldev_router`

## Requirements
- R1: One clock edge after the inputs are sampled, `devCs` is high exactly when the device is active, `aen` is low and `addr[9:3]` equals the effective base. `regIdx` then equals `addr[2:0]`, and it is 0 when `devCs` is low. `addr[11:10]` are ignored.
- R2: While `aen` is high, `devCs`, `rdEn` and `wrEn` are all low one edge later, whatever the address and strobes are.
- R3: `rdEn` equals `devCs` AND NOT `iorN`, and `wrEn` equals `devCs` AND NOT `iowN`. Both carry the same one-edge latency.
- R4: The effective IRQ level values 3, 4, 5, 6, 7, 9, 10, 11, 12 and 15 map to bits 0 to 9 of `irqOe`. One edge after the level is in effect, only the matching bit is set, so at most one bit of `irqOe` is ever high.
- R5: An effective level of 0, 1, 2, 8, 13 or 14 leaves all of `irqOe` and all of `irqOut` low.
- R6: With UART-bypass off, the routed request is the OR of `rxErrIrq`, `rxDataIrq`, `thrEmptyIrq` and `modemIrq`. The enabled line's `irqOut` bit follows that request one edge later and is driven low when the request is low.
- R7: An `irqOut` bit is never high while its `irqOe` bit is low, so a line that is not selected is released.
- R8: With `pnpBypass` high, the device is active regardless of the configuration registers. The base comes from `addrCfg`, encoded 0=0x3F8, 1=0x2F8, 2=0x3E8, 3=0x2E8, and the IRQ level is the value on `irqCfg`.
- R9: With `uartBypass` high, the routed request is `extIrq`, and the four internal sources have no effect on `irqOut`.
- R10: A high `cfgLoad` at an edge captures `cfgBase`, `cfgIrqLevel` and `cfgActive`, and these take effect on the outputs one edge later. Reset returns the registers to base 0, level 0 and inactive, and clears every output.
- R11: With `pnpBypass` low and the activate register clear, `devCs` stays low at every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 12 | I/O address |
| aen | input | 1 | Address enable; high during DMA cycles |
| iorN | input | 1 | Active-low I/O read strobe |
| iowN | input | 1 | Active-low I/O write strobe |
| cfgLoad | input | 1 | Capture strobe for the configuration inputs |
| cfgBase | input | 7 | Base address bits 9:3 |
| cfgIrqLevel | input | 4 | IRQ level number |
| cfgActive | input | 1 | Activate the logical device |
| pnpBypass | input | 1 | Use the strap pins instead of the configuration registers |
| addrCfg | input | 2 | Strap-selected base address code |
| irqCfg | input | 4 | Strap-selected IRQ level |
| uartBypass | input | 1 | Route extIrq instead of the internal sources |
| rxErrIrq | input | 1 | Receiver error interrupt source |
| rxDataIrq | input | 1 | Received data available or timeout source |
| thrEmptyIrq | input | 1 | Transmit holding register empty source |
| modemIrq | input | 1 | Enabled modem status change source |
| extIrq | input | 1 | External device interrupt |
| devCs | output | 1 | Device chip select |
| regIdx | output | 3 | Device register index |
| rdEn | output | 1 | Read enable |
| wrEn | output | 1 | Write enable |
| irqOut | output | 10 | IRQ line values (lines 3,4,5,6,7,9,10,11,12,15) |
| irqOe | output | 10 | IRQ line output enables |

## Verification
Each decode and IRQ output is due one rising edge after its inputs are applied. A configuration capture reaches the outputs one edge later again, because the captured registers feed the same output registers. The bench applies every stimulus on a falling edge and reads the outputs on the next falling edge. After each `cfgLoad` pulse it spends one cycle releasing the strobe before the next stimulus, so every comparison falls in the cycle where the result has settled. The address space, the strap codes and every combination of level, source and bypass setting are swept, and the expected values are computed arithmetically.

// File: rtl/isa_ldev_pkg.sv
package isa_ldev_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned DEC_HI  = 9;
  localparam int unsigned BASE_W  = DEC_HI - IDX_W + 1;
  localparam int unsigned LVL_W   = 4;
  localparam int unsigned NUM_IRQ = 10;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic              cs;
    logic              rd;
    logic              wr;
    logic              req;
    logic [IDX_W-1:0]  idx;
    logic [LVL_W-1:0]  level;
  } dec_strobe_t;

  // ISA line number carried by each IRQ output position
  function automatic logic [LVL_W-1:0] irqLineNum(input int unsigned pos);
    case (pos)
      0: irqLineNum = 4'd3;
      1: irqLineNum = 4'd4;
      2: irqLineNum = 4'd5;
      3: irqLineNum = 4'd6;
      4: irqLineNum = 4'd7;
      5: irqLineNum = 4'd9;
      6: irqLineNum = 4'd10;
      7: irqLineNum = 4'd11;
      8: irqLineNum = 4'd12;
      default: irqLineNum = 4'd15;
    endcase
  endfunction

  // Strap code to base bits 9:3: 0->3F8 1->2F8 2->3E8 3->2E8
  function automatic logic [BASE_W-1:0] bypassBase(input logic [1:0] sel);
    bypassBase = {1'b1, ~sel[0], 3'b111, ~sel[1], 1'b1};
  endfunction
endpackage

// File: rtl/isa_ldev_ctrl.sv
module isa_ldev_ctrl
  import isa_ldev_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     addr,
  input  logic              aen,
  input  logic              iorN,
  input  logic              iowN,
  input  logic              cfgLoad,
  input  logic [BASE_W-1:0] cfgBase,
  input  logic [LVL_W-1:0]  cfgIrqLevel,
  input  logic              cfgActive,
  input  logic              pnpBypass,
  input  logic [1:0]        addrCfg,
  input  logic [LVL_W-1:0]  irqCfg,
  input  logic              uartBypass,
  input  logic              rxErrIrq,
  input  logic              rxDataIrq,
  input  logic              thrEmptyIrq,
  input  logic              modemIrq,
  input  logic              extIrq,
  output dec_strobe_t       strb
);
  logic [BASE_W-1:0] baseReg;
  logic [LVL_W-1:0]  levelReg;
  logic              activeReg;

  logic [BASE_W-1:0] effBase;
  logic [LVL_W-1:0]  effLevel;
  logic              devActive;
  logic              addrHit;
  logic              intReq;

  // Configuration registers with power-up values
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg   <= '0;
      levelReg  <= '0;
      activeReg <= 1'b0;
    end else if (cfgLoad) begin
      baseReg   <= cfgBase;
      levelReg  <= cfgIrqLevel;
      activeReg <= cfgActive;
    end
  end

  always_comb begin
    effBase   = pnpBypass ? bypassBase(addrCfg) : baseReg;
    effLevel  = pnpBypass ? irqCfg : levelReg;
    devActive = pnpBypass | activeReg;
    addrHit   = (addr[DEC_HI:IDX_W] == effBase);
    intReq    = rxErrIrq | rxDataIrq | thrEmptyIrq | modemIrq;

    strb.cs    = devActive & ~aen & addrHit;
    strb.rd    = strb.cs & ~iorN;
    strb.wr    = strb.cs & ~iowN;
    strb.req   = uartBypass ? extIrq : intReq;
    strb.idx   = strb.cs ? addr[IDX_W-1:0] : '0;
    strb.level = effLevel;
  end

  // R2: a DMA cycle never selects the device
  a_r2_aen_deselect: assert property (@(posedge clk) disable iff (!rstN)
    aen |-> !strb.cs);

  // R11: an unconfigured device stays deselected outside bypass mode
  a_r11_inactive_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!pnpBypass && !activeReg) |-> !strb.cs);

  // R10: the first cycle after reset sees power-up configuration
  a_r10_reset_values: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (levelReg == '0 && baseReg == '0 && !activeReg));

  // R9: in UART-bypass mode the request tracks the external input
  a_r9_ext_route: assert property (@(posedge clk) disable iff (!rstN)
    uartBypass |-> (strb.req == extIrq));
endmodule

// File: rtl/isa_ldev_dp.sv
module isa_ldev_dp
  import isa_ldev_pkg::*;
#(
  parameter int unsigned NIRQ = NUM_IRQ
) (
  input  logic             clk,
  input  logic             rstN,
  input  dec_strobe_t      strb,
  output logic             devCs,
  output logic [IDX_W-1:0] regIdx,
  output logic             rdEn,
  output logic             wrEn,
  output logic [NIRQ-1:0]  irqOut,
  output logic [NIRQ-1:0]  irqOe
);
  logic [NIRQ-1:0] oeNext;

  generate
    for (genvar i = 0; i < NIRQ; i++) begin : g_line
      assign oeNext[i] = (strb.level == irqLineNum(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devCs  <= 1'b0;
      regIdx <= '0;
      rdEn   <= 1'b0;
      wrEn   <= 1'b0;
      irqOut <= '0;
      irqOe  <= '0;
    end else begin
      devCs  <= strb.cs;
      regIdx <= strb.idx;
      rdEn   <= strb.rd;
      wrEn   <= strb.wr;
      irqOe  <= oeNext;
      irqOut <= strb.req ? oeNext : '0;
    end
  end

  // R4: never more than one line enabled
  a_r4_single_line: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqOe));

  // R7: an unselected line is never driven high
  a_r7_released: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut & ~irqOe) == '0);

  // R3: access enables only while selected
  a_r3_rd_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn || wrEn) |-> devCs);

  // R3: a write strobe lands one edge later
  a_r3_wr_latency: assert property (@(posedge clk) disable iff (!rstN)
    strb.wr |=> wrEn);

  // R6: a request on an enabled line shows one edge later
  a_r6_req_latency: assert property (@(posedge clk) disable iff (!rstN)
    (strb.req && (oeNext != '0)) |=> (irqOut != '0));
endmodule

// File: rtl/isa_ldev_router.sv
module isa_ldev_router
  import isa_ldev_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [11:0]       addr,
  input  logic              aen,
  input  logic              iorN,
  input  logic              iowN,
  input  logic              cfgLoad,
  input  logic [6:0]        cfgBase,
  input  logic [3:0]        cfgIrqLevel,
  input  logic              cfgActive,
  input  logic              pnpBypass,
  input  logic [1:0]        addrCfg,
  input  logic [3:0]        irqCfg,
  input  logic              uartBypass,
  input  logic              rxErrIrq,
  input  logic              rxDataIrq,
  input  logic              thrEmptyIrq,
  input  logic              modemIrq,
  input  logic              extIrq,
  output logic              devCs,
  output logic [2:0]        regIdx,
  output logic              rdEn,
  output logic              wrEn,
  output logic [9:0]        irqOut,
  output logic [9:0]        irqOe
);
  dec_strobe_t strb;

  isa_ldev_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .aen(aen), .iorN(iorN), .iowN(iowN),
    .cfgLoad(cfgLoad), .cfgBase(cfgBase), .cfgIrqLevel(cfgIrqLevel),
    .cfgActive(cfgActive), .pnpBypass(pnpBypass), .addrCfg(addrCfg),
    .irqCfg(irqCfg), .uartBypass(uartBypass), .rxErrIrq(rxErrIrq),
    .rxDataIrq(rxDataIrq), .thrEmptyIrq(thrEmptyIrq), .modemIrq(modemIrq),
    .extIrq(extIrq), .strb(strb)
  );

  isa_ldev_dp #(.NIRQ(NUM_IRQ)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .devCs(devCs), .regIdx(regIdx),
    .rdEn(rdEn), .wrEn(wrEn), .irqOut(irqOut), .irqOe(irqOe)
  );
endmodule

// File: tb/sim_isa_ldev_router.sv
module sim_isa_ldev_router;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] addr = '0;
  logic aen = 1'b0, iorN = 1'b1, iowN = 1'b1;
  logic cfgLoad = 1'b0;
  logic [6:0] cfgBase = '0;
  logic [3:0] cfgIrqLevel = '0;
  logic cfgActive = 1'b0;
  logic pnpBypass = 1'b0;
  logic [1:0] addrCfg = '0;
  logic [3:0] irqCfg = '0;
  logic uartBypass = 1'b0;
  logic rxErrIrq = 1'b0, rxDataIrq = 1'b0, thrEmptyIrq = 1'b0, modemIrq = 1'b0, extIrq = 1'b0;
  logic devCs, rdEn, wrEn;
  logic [2:0] regIdx;
  logic [9:0] irqOut, irqOe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  isa_ldev_router u0 (.*);

  function automatic int lineIdx(input int lvl);
    case (lvl)
      3: return 0;   4: return 1;   5: return 2;  6: return 3;  7: return 4;
      9: return 5;   10: return 6;  11: return 7; 12: return 8; 15: return 9;
      default: return -1;
    endcase
  endfunction

  function automatic int strapBase(input int sel);
    case (sel)
      0: return 'h3F8;
      1: return 'h2F8;
      2: return 'h3E8;
      default: return 'h2E8;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; pulse cfgLoad for one edge, then release
  task automatic loadCfg(input logic [6:0] b, input logic [3:0] l, input logic a);
    cfgBase = b; cfgIrqLevel = l; cfgActive = a; cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // decode stimulus at a falling edge, check at the next falling edge
  task automatic decodeStep(input int a, input logic ae, input logic rn, input logic wn,
                            input logic active, input int base);
    logic eCs;
    addr = a[11:0]; aen = ae; iorN = rn; iowN = wn;
    @(negedge clk);
    eCs = active && !ae && ((a & 'h3F8) == base);
    chk(ae ? "R2 aen cs" : "R1 cs", {31'd0, devCs}, {31'd0, eCs});
    chk("R1 regIdx", {29'd0, regIdx}, eCs ? (a & 7) : 0);
    chk(ae ? "R2 aen rd/wr" : "R3 rd/wr", {30'd0, rdEn, wrEn}, {30'd0, eCs && !rn, eCs && !wn});
  endtask

  task automatic irqStep(input int lvl, input int src, input logic ub);
    int li;
    logic req;
    logic [9:0] eOe;
    {extIrq, modemIrq, thrEmptyIrq, rxDataIrq, rxErrIrq} = src[4:0];
    uartBypass = ub;
    @(negedge clk);
    li = lineIdx(lvl);
    eOe = (li < 0) ? 10'd0 : (10'd1 << li);
    req = ub ? src[4] : (src[3:0] != 0);
    chk(li < 0 ? "R5 no line oe" : "R4 oe", {22'd0, irqOe}, {22'd0, eOe});
    chk(ub ? "R9 ext route" : (li < 0 ? "R5 no line out" : "R6 out"),
        {22'd0, irqOut}, {22'd0, req ? eOe : 10'd0});
    chk("R7 released", {22'd0, irqOut & ~irqOe}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    @(negedge clk);
    // R10: reset state of the outputs
    chk("R10 reset outputs", {12'd0, devCs, regIdx, rdEn, wrEn, 1'b0}, 32'd0);
    chk("R10 reset irq", {12'd0, irqOut, irqOe}, 32'd0);
    // R11 and R10: base 0 from reset matches address 0 but device is inactive
    decodeStep('h000, 1'b0, 1'b0, 1'b0, 1'b0, 'h000);
    decodeStep('h005, 1'b0, 1'b0, 1'b1, 1'b0, 'h000);

    // R1, R2, R3: full address sweep with base 0x2D0 (bits 9:3 = 0x5A)
    loadCfg(7'h5A, 4'd4, 1'b1);
    for (int a = 0; a < 4096; a++)
      decodeStep(a, (a % 7) == 3, a[0] ^ a[4], a[1] ^ a[6], 1'b1, 'h2D0);

    // R10: a captured config cleared by reset
    doReset();
    decodeStep('h2D3, 1'b0, 1'b0, 1'b0, 1'b0, 'h2D0);
    chk("R10 level cleared", {22'd0, irqOe}, 32'd0);

    // R11: loaded but not activated
    loadCfg(7'h5A, 4'd4, 1'b0);
    for (int a = 'h2D0; a < 'h2D8; a++)
      decodeStep(a, 1'b0, 1'b0, 1'b0, 1'b0, 'h2D0);

    // R4, R5, R6, R7, R9: every level, source mix and bypass setting
    for (int lvl = 0; lvl < 16; lvl++) begin
      loadCfg(7'h00, lvl[3:0], 1'b1);
      for (int src = 0; src < 32; src++)
        for (int ub = 0; ub < 2; ub++)
          irqStep(lvl, src, ub[0]);
    end

    // R8: strap mode ignores registers (inactive, base 0, level 0)
    doReset();
    pnpBypass = 1'b1;
    for (int sel = 0; sel < 4; sel++) begin
      addrCfg = sel[1:0];
      irqCfg = 4'd3 + sel[3:0] * 4'd3;   // levels 3, 6, 9, 12
      for (int a = 0; a < 1024; a++)
        decodeStep(a + ((a % 5) << 10), 1'b0, a[2], ~a[2], 1'b1, strapBase(sel));
      irqStep(3 + sel * 3, 1, 1'b0);
      chk("R8 strap level", {22'd0, irqOe}, 32'd1 << lineIdx(3 + sel * 3));
    end
    irqCfg = 4'd13;
    irqStep(13, 15, 1'b0);
    pnpBypass = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule